// File: doc/BRIEF.md
# CRT Controller Register Interface

This block is the register side of a character-cell CRT controller. It sits behind an 8-bit I/O port pair in a small address window. A write to an even address in the window loads an index pointer. An odd address then writes, or reads, the register that the pointer selects. The block holds the horizontal and vertical timing values, the row and column counts, the character cell height, the display start address and the cursor registers. It drives all of them out to the raster engine as plain decoded values.

Two pieces of derived state are kept up to date. When either cursor address byte is written, the linear cursor offset relative to the display start is divided by the characters per row. An iterative divider does this, and it raises a busy flag while it works. The quotient gives the cursor row and the remainder gives the column. The cursor start and end scan-line registers are decoded without delay into a shape: hidden, a full block, one band, or a wrap-around cursor made of two bands (one at the top of the cell, one running from the start line to the bottom of the cell).

Top module: `crtc_regfile`

## Requirements
- R1: The window is IO_BASE (0x3D0) plus IO_SPAN (8) addresses, and all of them alias. A write to an even address in the window loads the 8-bit index. A write to an odd address writes the register the index selects: 0 horizontal total, 2 horizontal sync position, 3 horizontal sync width, 4 vertical total, 5 vertical adjust, 7 vertical sync position. Writes outside the window change nothing.
- R2: Index 1 (characters per row) stores the written value, saturated to MAX_COLS (80). A value of 0 is stored as written.
- R3: Index 8 (interlace) reads out as 2 after reset and after any write to it.
- R4: A write of 0 to index 6 (rows) clears display_en and leaves rows unchanged. A nonzero write stores the value and sets display_en.
- R5: Index 9 keeps bits [4:0] as the maximum scan line, and char_height equals that value plus 1.
- R6: Index 12 supplies the high byte and index 13 the low byte of the start address. start_addr is that 16-bit word address modulo REGEN_BYTES/2 (8192).
- R7: A write to index 14 (cursor high) or 15 (cursor low) sets cursor_busy at that clock edge. The block then computes offset = ({high,low} − start_addr) mod 2^16, cursor_y = offset / chars_per_row and cursor_x = offset mod chars_per_row. The results appear when busy drops. A new cursor write restarts the computation. A divisor of 0 gives x = y = 0.
- R8: A read at an odd window address returns bits [15:8] of (cursor_y × chars_per_row + cursor_x) when the index is 14, and bits [7:0] of it when the index is 15. A read returns 0 for every other index, at even addresses, and outside the window.
- R9: The cursor is hidden when bit 5 of index 10 (cursor start) is set, or when the start value exceeds CURS_LIMIT (7). When hidden, cursor_visible is 0 and all band fields are 0.
- R10: Index 11 (cursor end) keeps bits [4:0]. If the cursor is visible and the end exceeds CURS_LIMIT, the cursor is a block: band 0 starts at 0 with height CURS_LIMIT, and band 1 is zero.
- R11: If the cursor is visible and start ≤ end ≤ CURS_LIMIT, there is one band at start[4:0] with height end − start + 1, and band 1 is zero.
- R12: If the cursor is visible and start > end, band 0 starts at 0 with height end. Band 1 starts at start[4:0] with height char_height − start, clamped to 0.
- R13: After reset: chars_per_row 80, rows 25, display_en 1, char_height 8, interlace 2, start_addr 0, cursor x/y 0, busy 0, and the cursor is visible as a one-line band at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address (combinational) |
| h_total | output | 8 | Horizontal total |
| h_sync_pos | output | 8 | Horizontal sync position |
| h_sync_width | output | 8 | Horizontal sync width |
| v_total | output | 8 | Vertical total |
| v_adjust | output | 8 | Vertical total adjust |
| v_sync_pos | output | 8 | Vertical sync position |
| interlace | output | 8 | Interlace setting (fixed) |
| chars_per_row | output | 8 | Displayed characters per row |
| rows | output | 8 | Displayed character rows |
| display_en | output | 1 | Display enabled (cleared by a zero row count) |
| char_height | output | 6 | Scan lines per character cell |
| start_addr | output | START_W | Display start word address |
| cursor_x | output | 8 | Cursor column |
| cursor_y | output | 16 | Cursor row |
| cursor_busy | output | 1 | Cursor row/column computation in progress |
| cursor_visible | output | 1 | Cursor shown |
| band0_start | output | 5 | First band start line |
| band0_height | output | 6 | First band height in lines |
| band1_start | output | 5 | Second band start line |
| band1_height | output | 6 | Second band height in lines |

## Verification
The bench checks the characters-per-row clamp at exactly 80 and one above it. A design with an off-by-one compare would pass 81 or clip 80. It writes a zero row count twice to show that the row value survives, which a design that stored the zero would lose. Cursor addresses below the start address check the 16-bit wrap of the offset. A zero column count, a cursor write made while the divider is still busy, and the last cell of an 80×25 screen check the divider's edges. For the cursor shape, the bench covers a masked end value, a start equal to the limit, a block, and a wrap whose lower band would go negative. A design that got these wrong would show the cursor where it should be hidden, or report a huge band height.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   localparam int DATA_W = 8;
   localparam int OFS_W  = 2 * DATA_W;
   localparam int SCAN_W = 5;
   localparam int HGT_W  = SCAN_W + 1;

   localparam logic [DATA_W-1:0] ILACE_FIXED = 8'd2;

   typedef enum logic [3:0] {
      RG_HTOTAL  = 4'h0,
      RG_COLS    = 4'h1,
      RG_HSYNC   = 4'h2,
      RG_HWIDTH  = 4'h3,
      RG_VTOTAL  = 4'h4,
      RG_VADJ    = 4'h5,
      RG_ROWS    = 4'h6,
      RG_VSYNC   = 4'h7,
      RG_ILACE   = 4'h8,
      RG_MAXSCAN = 4'h9,
      RG_CSTART  = 4'hA,
      RG_CEND    = 4'hB,
      RG_STARTHI = 4'hC,
      RG_STARTLO = 4'hD,
      RG_CURHI   = 4'hE,
      RG_CURLO   = 4'hF
   } crtc_reg_e;

   typedef struct packed {
      logic              visible;
      logic [SCAN_W-1:0] b0_start;
      logic [HGT_W-1:0]  b0_height;
      logic [SCAN_W-1:0] b1_start;
      logic [HGT_W-1:0]  b1_height;
   } cursor_shape_t;

endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode #(
   parameter int ADDR_W  = 16,
   parameter int IO_BASE = 16'h03D0,
   parameter int IO_SPAN = 8
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   output logic              idx_we,
   output logic              data_we,
   output logic              data_sel
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] MASK_A = ~ADDR_W'(IO_SPAN - 1);

   generate
      if (IO_SPAN < 2 || (IO_SPAN & (IO_SPAN - 1)) != 0) begin : g_bad_span
         $error("IO_SPAN must be a power of two of at least 2");
      end
      if ((IO_BASE % IO_SPAN) != 0) begin : g_bad_base
         $error("IO_BASE must be aligned to IO_SPAN");
      end
   endgenerate

   logic hit;

   always_comb begin
      hit      = (io_addr & MASK_A) == BASE_A;
      idx_we   = io_wr & hit & ~io_addr[0];
      data_we  = io_wr & hit &  io_addr[0];
      data_sel = hit & io_addr[0];
   end

endmodule

// File: rtl/crtc_divider.sv
module crtc_divider #(
   parameter int DVD_W = 16,
   parameter int DVS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             busy,
   output logic [DVD_W-1:0] quotient,
   output logic [DVS_W-1:0] remainder
);
   localparam int CNT_W = $clog2(DVD_W + 1);

   generate
      if (DVD_W < 2 || DVS_W < 1) begin : g_bad_width
         $error("divider widths too small");
      end
   endgenerate

   logic [DVD_W-1:0] quo_q, quo_n, quot_out_q;
   logic [DVS_W-1:0] rem_q, rem_n, dvs_q, rem_out_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [DVS_W:0]   rem_sh;
   logic             ge;

   always_comb begin
      rem_sh = {rem_q, quo_q[DVD_W-1]};
      ge     = rem_sh >= {1'b0, dvs_q};
      rem_n  = ge ? DVS_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVS_W-1:0];
      quo_n  = {quo_q[DVD_W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q      <= '0;
         rem_q      <= '0;
         dvs_q      <= '0;
         cnt_q      <= '0;
         busy_q     <= 1'b0;
         quot_out_q <= '0;
         rem_out_q  <= '0;
      end else if (start) begin
         quo_q  <= dividend;
         rem_q  <= '0;
         dvs_q  <= divisor;
         cnt_q  <= CNT_W'(DVD_W);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         quo_q <= quo_n;
         rem_q <= rem_n;
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            busy_q     <= 1'b0;
            quot_out_q <= (dvs_q == '0) ? '0 : quo_n;
            rem_out_q  <= (dvs_q == '0) ? '0 : rem_n;
         end
      end
   end

   assign busy      = busy_q;
   assign quotient  = quot_out_q;
   assign remainder = rem_out_q;

endmodule

// File: rtl/crtc_cursor_shape.sv
module crtc_cursor_shape
   import crtc_pkg::*;
#(
   parameter int CURS_LIMIT = 7
) (
   input  logic [DATA_W-1:0] start_reg,
   input  logic [SCAN_W-1:0] end_reg,
   input  logic [HGT_W-1:0]  char_height,
   output cursor_shape_t     shape
);
   localparam logic [DATA_W-1:0] LIM_D = DATA_W'(CURS_LIMIT);
   localparam logic [SCAN_W-1:0] LIM_S = SCAN_W'(CURS_LIMIT);
   localparam logic [HGT_W-1:0]  LIM_H = HGT_W'(CURS_LIMIT);

   generate
      if (CURS_LIMIT < 1 || CURS_LIMIT >= (1 << SCAN_W)) begin : g_bad_limit
         $error("CURS_LIMIT out of range");
      end
   endgenerate

   logic [SCAN_W-1:0] st5;
   logic              hidden;
   logic              block;
   logic [HGT_W-1:0]  st_h, end_h;

   always_comb begin
      st5    = start_reg[SCAN_W-1:0];
      st_h   = {1'b0, st5};
      end_h  = {1'b0, end_reg};
      hidden = start_reg[5] | (start_reg > LIM_D);
      block  = end_reg > LIM_S;
      shape  = '0;
      if (!hidden) begin
         shape.visible = 1'b1;
         if (block) begin
            shape.b0_height = LIM_H;
         end else if (st5 <= end_reg) begin
            shape.b0_start  = st5;
            shape.b0_height = end_h - st_h + 1'b1;
         end else begin
            shape.b0_height = end_h;
            shape.b1_start  = st5;
            shape.b1_height = (char_height > st_h) ? (char_height - st_h) : '0;
         end
      end
   end

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
   import crtc_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int IO_BASE       = 16'h03D0,
   parameter int IO_SPAN       = 8,
   parameter int MAX_COLS      = 80,
   parameter int RESET_ROWS    = 25,
   parameter int RESET_MAXSCAN = 7,
   parameter int REGEN_BYTES   = 16384,
   parameter int CURS_LIMIT    = 7,
   localparam int START_W      = $clog2(REGEN_BYTES / 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic [7:0]         h_total,
   output logic [7:0]         h_sync_pos,
   output logic [7:0]         h_sync_width,
   output logic [7:0]         v_total,
   output logic [7:0]         v_adjust,
   output logic [7:0]         v_sync_pos,
   output logic [7:0]         interlace,
   output logic [7:0]         chars_per_row,
   output logic [7:0]         rows,
   output logic               display_en,
   output logic [5:0]         char_height,
   output logic [START_W-1:0] start_addr,
   output logic [7:0]         cursor_x,
   output logic [15:0]        cursor_y,
   output logic               cursor_busy,
   output logic               cursor_visible,
   output logic [4:0]         band0_start,
   output logic [5:0]         band0_height,
   output logic [4:0]         band1_start,
   output logic [5:0]         band1_height
);
   localparam logic [DATA_W-1:0] MAXC_D = DATA_W'(MAX_COLS);
   localparam int LIN_W = OFS_W + DATA_W;

   generate
      if (MAX_COLS < 1 || MAX_COLS > 255) begin : g_bad_cols
         $error("MAX_COLS must fit in one byte");
      end
      if ((REGEN_BYTES & (REGEN_BYTES - 1)) != 0) begin : g_bad_regen
         $error("REGEN_BYTES must be a power of two");
      end
      if (START_W <= DATA_W || START_W > OFS_W) begin : g_bad_start
         $error("start address width must lie between one and two bytes");
      end
   endgenerate

   // ---------------- port decode ----------------
   logic idx_we, data_we, data_sel;

   crtc_port_decode #(
      .ADDR_W (ADDR_W),
      .IO_BASE(IO_BASE),
      .IO_SPAN(IO_SPAN)
   ) decode_i (
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .idx_we  (idx_we),
      .data_we (data_we),
      .data_sel(data_sel)
   );

   // ---------------- register state ----------------
   logic [DATA_W-1:0]  index_q;
   logic [DATA_W-1:0]  htot_q, hsync_q, hwid_q, vtot_q, vadj_q, vsync_q, ilace_q;
   logic [DATA_W-1:0]  cols_q, rows_q;
   logic               disp_q;
   logic [SCAN_W-1:0]  maxscan_q;
   logic [DATA_W-1:0]  cstart_q;
   logic [SCAN_W-1:0]  cend_q;
   logic [START_W-1:0] start_q;
   logic [DATA_W-1:0]  curhi_q, curlo_q;

   logic       reg_hit;
   crtc_reg_e  reg_sel;

   always_comb begin
      reg_hit = index_q[7:4] == 4'h0;
      reg_sel = crtc_reg_e'(index_q[3:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q   <= '0;
         htot_q    <= '0;
         hsync_q   <= '0;
         hwid_q    <= '0;
         vtot_q    <= '0;
         vadj_q    <= '0;
         vsync_q   <= '0;
         ilace_q   <= ILACE_FIXED;
         cols_q    <= MAXC_D;
         rows_q    <= DATA_W'(RESET_ROWS);
         disp_q    <= 1'b1;
         maxscan_q <= SCAN_W'(RESET_MAXSCAN);
         cstart_q  <= '0;
         cend_q    <= '0;
         start_q   <= '0;
         curhi_q   <= '0;
         curlo_q   <= '0;
      end else if (idx_we) begin
         index_q <= io_wdata;
      end else if (data_we && reg_hit) begin
         unique case (reg_sel)
            RG_HTOTAL:  htot_q  <= io_wdata;
            RG_COLS:    cols_q  <= (io_wdata > MAXC_D) ? MAXC_D : io_wdata;
            RG_HSYNC:   hsync_q <= io_wdata;
            RG_HWIDTH:  hwid_q  <= io_wdata;
            RG_VTOTAL:  vtot_q  <= io_wdata;
            RG_VADJ:    vadj_q  <= io_wdata;
            RG_ROWS: begin
               if (io_wdata == '0) begin
                  disp_q <= 1'b0;
               end else begin
                  rows_q <= io_wdata;
                  disp_q <= 1'b1;
               end
            end
            RG_VSYNC:   vsync_q   <= io_wdata;
            RG_ILACE:   ilace_q   <= ILACE_FIXED;
            RG_MAXSCAN: maxscan_q <= io_wdata[SCAN_W-1:0];
            RG_CSTART:  cstart_q  <= io_wdata;
            RG_CEND:    cend_q    <= io_wdata[SCAN_W-1:0];
            RG_STARTHI: start_q   <= START_W'({io_wdata, start_q[DATA_W-1:0]});
            RG_STARTLO: start_q[DATA_W-1:0] <= io_wdata;
            RG_CURHI:   curhi_q   <= io_wdata;
            RG_CURLO:   curlo_q   <= io_wdata;
            default: ;
         endcase
      end
   end

   // ---------------- cursor position ----------------
   logic             cur_launch;
   logic [DATA_W-1:0] new_hi, new_lo;
   logic [OFS_W-1:0] cur_ofs;

   always_comb begin
      cur_launch = data_we && reg_hit && (reg_sel == RG_CURHI || reg_sel == RG_CURLO);
      new_hi     = (reg_sel == RG_CURHI) ? io_wdata : curhi_q;
      new_lo     = (reg_sel == RG_CURLO) ? io_wdata : curlo_q;
      cur_ofs    = {new_hi, new_lo} - {{(OFS_W - START_W){1'b0}}, start_q};
   end

   crtc_divider #(
      .DVD_W(OFS_W),
      .DVS_W(DATA_W)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cur_launch),
      .dividend (cur_ofs),
      .divisor  (cols_q),
      .busy     (cursor_busy),
      .quotient (cursor_y),
      .remainder(cursor_x)
   );

   // ---------------- cursor shape ----------------
   cursor_shape_t shape;

   crtc_cursor_shape #(
      .CURS_LIMIT(CURS_LIMIT)
   ) shape_i (
      .start_reg  (cstart_q),
      .end_reg    (cend_q),
      .char_height(char_height),
      .shape      (shape)
   );

   // ---------------- read path ----------------
   logic [LIN_W-1:0] lin;

   always_comb begin
      lin = ({{DATA_W{1'b0}}, cursor_y} * {{OFS_W{1'b0}}, cols_q})
          + {{OFS_W{1'b0}}, cursor_x};
      io_rdata = '0;
      if (data_sel && reg_hit) begin
         if (reg_sel == RG_CURHI)      io_rdata = lin[15:8];
         else if (reg_sel == RG_CURLO) io_rdata = lin[7:0];
      end
   end

   // ---------------- outputs ----------------
   assign h_total        = htot_q;
   assign h_sync_pos     = hsync_q;
   assign h_sync_width   = hwid_q;
   assign v_total        = vtot_q;
   assign v_adjust       = vadj_q;
   assign v_sync_pos     = vsync_q;
   assign interlace      = ilace_q;
   assign chars_per_row  = cols_q;
   assign rows           = rows_q;
   assign display_en     = disp_q;
   assign char_height    = {1'b0, maxscan_q} + 1'b1;
   assign start_addr     = start_q;
   assign cursor_visible = shape.visible;
   assign band0_start    = shape.b0_start;
   assign band0_height   = shape.b0_height;
   assign band1_start    = shape.b1_start;
   assign band1_height   = shape.b1_height;

endmodule

// File: rtl/crtc_regfile_chk.sv
module crtc_regfile_chk #(
   parameter int MAX_COLS = 80
) (
   input logic        clk,
   input logic        rst_n,
   input logic        data_we,
   input logic [7:0]  idx,
   input logic [7:0]  wdata,
   input logic [7:0]  cols,
   input logic [7:0]  ilace,
   input logic [7:0]  rows,
   input logic        disp,
   input logic [5:0]  ch,
   input logic        busy,
   input logic [7:0]  cx,
   input logic [15:0] cy,
   input logic        vis,
   input logic [4:0]  b0s,
   input logic [5:0]  b0h,
   input logic [5:0]  b1h
);
   // R2
   cols_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cols <= 8'(MAX_COLS));

   // R3
   ilace_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && idx == 8'h08) |=> (ilace == 8'd2));

   // R4
   rows_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && idx == 8'h06 && wdata == 8'h00) |=> (!disp && $stable(rows)));

   // R5
   height_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && idx == 8'h09) |=> (ch == ({1'b0, $past(wdata[4:0])} + 6'd1)));

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && (idx == 8'h0E || idx == 8'h0F)) |=> busy);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cx) || !$stable(cy)) |-> $past(busy));

   // R9
   hidden_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vis |-> (b0h == 6'd0 && b1h == 6'd0));

   // R12
   wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b1h != 6'd0) |-> (b0s == 5'd0 && vis));

endmodule

bind crtc_regfile crtc_regfile_chk #(
   .MAX_COLS(MAX_COLS)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .data_we(data_we),
   .idx    (index_q),
   .wdata  (io_wdata),
   .cols   (chars_per_row),
   .ilace  (interlace),
   .rows   (rows),
   .disp   (display_en),
   .ch     (char_height),
   .busy   (cursor_busy),
   .cx     (cursor_x),
   .cy     (cursor_y),
   .vis    (cursor_visible),
   .b0s    (band0_start),
   .b0h    (band0_height),
   .b1h    (band1_height)
);

// File: tb/crtc_regfile_tb_top.sv
`timescale 1ns/1ps
module crtc_regfile_tb_top;
   localparam logic [15:0] BASE = 16'h03D0;
   localparam int NVEC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [7:0]  h_total, h_sync_pos, h_sync_width, v_total, v_adjust, v_sync_pos;
   logic [7:0]  interlace, chars_per_row, rows;
   logic        display_en;
   logic [5:0]  char_height;
   logic [12:0] start_addr;
   logic [7:0]  cursor_x;
   logic [15:0] cursor_y;
   logic        cursor_busy, cursor_visible;
   logic [4:0]  band0_start, band1_start;
   logic [5:0]  band0_height, band1_height;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   crtc_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .h_total(h_total), .h_sync_pos(h_sync_pos), .h_sync_width(h_sync_width),
      .v_total(v_total), .v_adjust(v_adjust), .v_sync_pos(v_sync_pos),
      .interlace(interlace), .chars_per_row(chars_per_row), .rows(rows),
      .display_en(display_en), .char_height(char_height), .start_addr(start_addr),
      .cursor_x(cursor_x), .cursor_y(cursor_y), .cursor_busy(cursor_busy),
      .cursor_visible(cursor_visible), .band0_start(band0_start),
      .band0_height(band0_height), .band1_start(band1_start),
      .band1_height(band1_height)
   );

   // {index, value, selector, expected}
   localparam logic [35:0] VEC [NVEC] = '{
      {8'h00, 8'h71, 4'd0,  16'h0071},   // R1
      {8'h01, 8'h64, 4'd1,  16'h0050},   // R2 100 -> 80
      {8'h01, 8'h50, 4'd1,  16'h0050},   // R2 exactly 80
      {8'h01, 8'h51, 4'd1,  16'h0050},   // R2 81 -> 80
      {8'h01, 8'h28, 4'd1,  16'h0028},   // R2
      {8'h02, 8'h5A, 4'd2,  16'h005A},   // R1
      {8'h03, 8'h0A, 4'd3,  16'h000A},   // R1
      {8'h04, 8'h1F, 4'd4,  16'h001F},   // R1
      {8'h05, 8'h06, 4'd5,  16'h0006},   // R1
      {8'h07, 8'h1C, 4'd6,  16'h001C},   // R1
      {8'h08, 8'h55, 4'd7,  16'h0002},   // R3
      {8'h06, 8'h00, 4'd8,  16'h0000},   // R4 display off
      {8'h06, 8'h00, 4'd9,  16'h0019},   // R4 rows kept
      {8'h06, 8'h1E, 4'd8,  16'h0001},   // R4 display on
      {8'h06, 8'h1E, 4'd9,  16'h001E},   // R4
      {8'h09, 8'h0D, 4'd10, 16'h000E},   // R5
      {8'h09, 8'hFF, 4'd10, 16'h0020},   // R5 masked
      {8'h09, 8'h0D, 4'd10, 16'h000E},   // R5
      {8'h0C, 8'h25, 4'd11, 16'h0500},   // R6 modulo 8192
      {8'h0D, 8'h10, 4'd11, 16'h0510}    // R6
   };

   function automatic logic [15:0] pick(input logic [3:0] sel);
      case (sel)
         4'd0:  pick = {8'h0, h_total};
         4'd1:  pick = {8'h0, chars_per_row};
         4'd2:  pick = {8'h0, h_sync_pos};
         4'd3:  pick = {8'h0, h_sync_width};
         4'd4:  pick = {8'h0, v_total};
         4'd5:  pick = {8'h0, v_adjust};
         4'd6:  pick = {8'h0, v_sync_pos};
         4'd7:  pick = {8'h0, interlace};
         4'd8:  pick = {15'h0, display_en};
         4'd9:  pick = {8'h0, rows};
         4'd10: pick = {10'h0, char_height};
         default: pick = {3'h0, start_addr};
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
      io_write(BASE, idx);
      io_write(BASE + 16'd1, d);
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wr = 1'b0;
      #1 d = io_rdata;
   endtask

   task automatic wait_idle();
      while (cursor_busy) @(negedge clk);
   endtask

   task automatic chk_shape(input string tag, input logic v, input logic [4:0] s0,
                            input logic [5:0] h0, input logic [4:0] s1, input logic [5:0] h1);
      chk({tag, " visible"}, {31'h0, cursor_visible}, {31'h0, v});
      chk({tag, " band0"}, {21'h0, band0_start, band0_height}, {21'h0, s0, h0});
      chk({tag, " band1"}, {21'h0, band1_start, band1_height}, {21'h0, s1, h1});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      chk("R13 cols", {24'h0, chars_per_row}, 32'd80);
      chk("R13 rows", {24'h0, rows}, 32'd25);
      chk("R13 display_en", {31'h0, display_en}, 32'd1);
      chk("R13 char_height", {26'h0, char_height}, 32'd8);
      chk("R13 interlace", {24'h0, interlace}, 32'd2);
      chk("R13 start", {19'h0, start_addr}, 32'd0);
      chk("R13 cursor", {8'h0, cursor_y, cursor_x}, 32'd0);
      chk("R13 busy", {31'h0, cursor_busy}, 32'd0);
      chk_shape("R13 shape", 1'b1, 5'd0, 6'd1, 5'd0, 6'd0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         set_reg(VEC[i][35:28], VEC[i][27:20]);
         chk($sformatf("vector %0d (R1..R6 table)", i),
             {16'h0, pick(VEC[i][19:16])}, {16'h0, VEC[i][15:0]});
      end

      // R1 window decode and aliasing
      io_write(16'h03D6, 8'h00);
      io_write(16'h03B5, 8'h11);
      chk("R1 outside window ignored", {24'h0, h_total}, 32'h71);
      io_write(16'h03D8, 8'h33);
      chk("R1 address above window ignored", {24'h0, h_total}, 32'h71);
      io_write(16'h03D7, 8'h22);
      chk("R1 odd alias writes data", {24'h0, h_total}, 32'h22);

      // R7 cursor: cols 40, start 0x0510
      set_reg(8'h0E, 8'h05);
      chk("R7 busy after cursor write", {31'h0, cursor_busy}, 32'd1);
      wait_idle();
      chk("R7 wrapped offset row", {16'h0, cursor_y}, 32'd1638);
      chk("R7 wrapped offset col", {24'h0, cursor_x}, 32'd0);
      set_reg(8'h0F, 8'h65);
      wait_idle();
      chk("R7 row", {16'h0, cursor_y}, 32'd2);
      chk("R7 col", {24'h0, cursor_x}, 32'd5);

      // R8 readback
      io_write(BASE, 8'h0E);
      io_read(BASE + 16'd1, rd);
      chk("R8 read high", {24'h0, rd}, 32'h00);
      io_write(BASE, 8'h0F);
      io_read(BASE + 16'd3, rd);
      chk("R8 read low", {24'h0, rd}, 32'h55);
      io_read(BASE + 16'd2, rd);
      chk("R8 even port reads zero", {24'h0, rd}, 32'h00);
      io_read(16'h03E1, rd);
      chk("R8 outside window reads zero", {24'h0, rd}, 32'h00);
      io_write(BASE, 8'h10);
      io_read(BASE + 16'd1, rd);
      chk("R8 index 0x10 reads zero", {24'h0, rd}, 32'h00);
      io_write(BASE, 8'h00);
      io_read(BASE + 16'd1, rd);
      chk("R8 unsupported index reads zero", {24'h0, rd}, 32'h00);

      // R2 / R7 zero columns
      set_reg(8'h01, 8'h00);
      chk("R2 zero columns stored", {24'h0, chars_per_row}, 32'd0);
      set_reg(8'h0F, 8'h65);
      wait_idle();
      chk("R7 zero divisor", {8'h0, cursor_y, cursor_x}, 32'd0);

      // R7 last cell of 80x25, restart while busy
      set_reg(8'h01, 8'h50);
      set_reg(8'h0C, 8'h00);
      set_reg(8'h0D, 8'h00);
      chk("R6 start cleared", {19'h0, start_addr}, 32'd0);
      io_write(BASE, 8'h0E);
      io_write(BASE + 16'd1, 8'h07);
      io_write(BASE, 8'h0F);
      io_write(BASE + 16'd1, 8'hCF);
      wait_idle();
      chk("R7 restart row", {16'h0, cursor_y}, 32'd24);
      chk("R7 restart col", {24'h0, cursor_x}, 32'd79);
      io_write(BASE, 8'h0E);
      io_read(BASE + 16'd1, rd);
      chk("R8 read high 1999", {24'h0, rd}, 32'h07);
      io_write(BASE, 8'h0F);
      io_read(BASE + 16'd1, rd);
      chk("R8 read low 1999", {24'h0, rd}, 32'hCF);

      // cursor shape, char_height 14
      set_reg(8'h0A, 8'h06);
      set_reg(8'h0B, 8'h07);
      chk_shape("R11 normal", 1'b1, 5'd6, 6'd2, 5'd0, 6'd0);
      set_reg(8'h0A, 8'h26);
      chk_shape("R9 bit5 hidden", 1'b0, 5'd0, 6'd0, 5'd0, 6'd0);
      set_reg(8'h0A, 8'h08);
      chk_shape("R9 start over limit", 1'b0, 5'd0, 6'd0, 5'd0, 6'd0);
      set_reg(8'h0A, 8'h07);
      chk_shape("R11 start equals end", 1'b1, 5'd7, 6'd1, 5'd0, 6'd0);
      set_reg(8'h0A, 8'h02);
      set_reg(8'h0B, 8'h09);
      chk_shape("R10 block", 1'b1, 5'd0, 6'd7, 5'd0, 6'd0);
      set_reg(8'h0B, 8'h23);
      chk_shape("R10 end masked", 1'b1, 5'd2, 6'd2, 5'd0, 6'd0);
      set_reg(8'h0A, 8'h06);
      set_reg(8'h0B, 8'h02);
      chk_shape("R12 wrap", 1'b1, 5'd0, 6'd2, 5'd6, 6'd8);
      set_reg(8'h09, 8'h03);
      chk_shape("R12 wrap clamped", 1'b1, 5'd0, 6'd2, 5'd6, 6'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule